// File: doc/BRIEF.md
# Register-Mapped TMDS Symbol Encoder

This peripheral turns packed colour data into 10-bit transition-minimised, DC-balanced symbols for three video lanes. It is driven entirely by software through a small register window. A processor first writes a 32-bit colour word. It then reads back one of two results:

- the symbols for one pixel on all three lanes, packed into one word;
- the symbols for two consecutive pixels on a single lane.

Each lane finds its colour bits in the same way. The low half of the colour word is rotated right, and the low byte of the result is masked down to a programmable number of most significant bits. Each lane keeps its own signed running disparity.

Reads come in two kinds. A consuming read advances the colour word by a programmable pixel shift and commits the new disparity. A preview read returns the same symbols and leaves every piece of state unchanged. A write to the control word with the clear bit set zeroes all three disparities.

Word addresses on the bus:

| Address | Function |
|---------|----------|
| 0 | Control |
| 1 | Colour data (write-only) |
| 2 | Single preview |
| 3 | Single consume |
| 4 and 5 | Lane 0 double-pixel preview and consume |
| 6 and 7 | Lane 1 double-pixel preview and consume |
| 8 and 9 | Lane 2 double-pixel preview and consume |

Read data is combinational from the address while `busRead` is high. Side effects take place at the next rising clock edge.

Top module: `tmds_reg_encoder`

## Requirements
- R1: After reset, the control word reads as zero, the colour word is zero, and all three running disparities are zero.
- R2: Control word fields:
  - lane k rotate amount: bits [4k+3:4k];
  - lane k width code: bits [12+3k+2:12+3k];
  - interleave flag: bit 23, stored only;
  - pixel shift code: bits 26:24;
  - no-shift flag: bit 27;
  - bit 28 is a strobe that is not stored.

  A read of the control word returns these fields as written. Bits 31:28 and 22:21 read as zero.
- R3: For each lane, bits 15:0 of the colour word are rotated right by that lane's rotate amount. The low 8 bits of the result are taken, the top (n+1) of them are kept (n is the width code), and the rest are set to zero.
- R4: Each lane encodes its byte as standard TMDS video data:
  - an XNOR chain when the ones count is above 4, or equal to 4 with bit 0 clear, and an XOR chain otherwise; symbol bit 8 is 1 for XOR;
  - then the usual disparity-dependent inversion of bits 7:0, with bit 9 marking the inversion;
  - the signed running disparity is updated.
- R5: A single read returns lane 0 in bits 9:0, lane 1 in bits 19:10 and lane 2 in bits 29:20. Bits 31:30 read as zero.
- R6: A double read for lane k returns the first pixel in bits 9:0 and the second in bits 25:16, with the other bits zero. The second pixel is encoded with the disparity left by the first. Its colour is the colour word shifted once, or the unshifted word when the no-shift flag is set.
- R7: A preview read (address 2, 4, 6 or 8) changes no state. The same read repeated returns the same word.
- R8: A single consume (address 3) returns the same word as a preview and then commits all three lanes' disparities. It also shifts the colour word right, zero-filled, by 2^s bits for shift code s; code 0 means no shift, and shifts of 32 or more clear the word.
- R9: A double consume for lane k (address 5, 7 or 9) commits only lane k's disparity after both pixels. The colour word is shifted twice, or once when the no-shift flag is set.
- R10: A control write with bit 28 set zeroes all three disparities.
- R11: Read data is zero when `busRead` is low, on reads of address 1, and on addresses 10 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |

## Verification
The assertions assume that a bus master never raises `busWrite` and `busRead` in the same cycle. The preview-stability property also assumes the bus is otherwise quiet between two back-to-back previews. The stimulus drives exactly one operation per cycle, so both conditions always hold. The assertion on cleared disparity relies on the read that directly follows the clear being a single preview; the stimulus issues plenty of those sequences. All other stimulus is a weighted mix of control writes with random field values, colour writes, previews and consumes, so every lane sees both disparity signs and every shift code.

// File: rtl/tmds_reg_pkg.sv
package tmds_reg_pkg;
  localparam int LANES = 3;
  localparam int WORD_W = 32;
  localparam int SYM_W = 10;
  localparam int ROT_W = 4;
  localparam int NB_W = 3;
  localparam int SH_W = 3;

  // Word addresses (decoded by software drivers, so they are fixed)
  localparam logic [3:0] ADR_CTRL = 4'd0;
  localparam logic [3:0] ADR_COLOUR = 4'd1;
  localparam logic [3:0] ADR_PEEK1 = 4'd2;
  localparam logic [3:0] ADR_POP1 = 4'd3;
  localparam logic [3:0] ADR_DBL_BASE = 4'd4;
  localparam int CLR_BIT = 28;

  typedef struct packed {
    logic noShift;
    logic [SH_W-1:0] pixShift;
    logic interleave;
    logic [LANES-1:0][NB_W-1:0] nbits;
    logic [LANES-1:0][ROT_W-1:0] rot;
  } cfg_t;

  typedef struct packed {
    logic wrColour;
    logic clearBal;
    logic popSingle;
    logic [LANES-1:0] popDouble;
  } strobe_t;

  function automatic logic [7:0] laneBits(input logic [WORD_W-1:0] w,
                                          input logic [ROT_W-1:0] rot,
                                          input logic [NB_W-1:0] nb);
    logic [31:0] twice;
    logic [31:0] turned;
    logic [7:0] keep;
    twice = {w[15:0], w[15:0]};
    turned = twice >> rot;
    keep = 8'hFF << (3'd7 - nb);
    return turned[7:0] & keep;
  endfunction
endpackage

// File: rtl/tmds_lane_enc.sv
module tmds_lane_enc #(
  parameter int BAL_W = 6
) (
  input  logic [7:0] dataIn,
  input  logic signed [BAL_W-1:0] balIn,
  output logic [9:0] sym,
  output logic signed [BAL_W-1:0] balOut
);
  localparam logic signed [BAL_W-1:0] EIGHT = BAL_W'(8);
  localparam logic signed [BAL_W-1:0] TWO = BAL_W'(2);
  localparam logic signed [BAL_W-1:0] NONE = '0;

  logic [3:0] onesD;
  logic [3:0] onesQ;
  logic useXnor;
  logic [8:0] qm;
  logic signed [BAL_W-1:0] onesS;
  logic signed [BAL_W-1:0] zerosS;
  logic balPos;
  logic balNeg;

  always_comb begin
    onesD = 4'($countones(dataIn));
    useXnor = (onesD > 4'd4) || (onesD == 4'd4 && !dataIn[0]);
    qm = '0;
    qm[0] = dataIn[0];
    for (int i = 1; i < 8; i++) begin
      qm[i] = useXnor ? ~(qm[i-1] ^ dataIn[i]) : (qm[i-1] ^ dataIn[i]);
    end
    qm[8] = ~useXnor;
  end

  always_comb begin
    onesQ = 4'($countones(qm[7:0]));
    onesS = {{(BAL_W-4){1'b0}}, onesQ};
    zerosS = EIGHT - onesS;
    balNeg = balIn[BAL_W-1];
    balPos = !balNeg && (balIn != NONE);
    if (balIn == NONE || onesQ == 4'd4) begin
      sym = {~qm[8], qm[8], (qm[8] ? qm[7:0] : ~qm[7:0])};
      balOut = qm[8] ? (balIn + onesS - zerosS) : (balIn + zerosS - onesS);
    end else if ((balPos && onesQ > 4'd4) || (balNeg && onesQ < 4'd4)) begin
      sym = {1'b1, qm[8], ~qm[7:0]};
      balOut = balIn + (qm[8] ? TWO : NONE) + zerosS - onesS;
    end else begin
      sym = {1'b0, qm[8], qm[7:0]};
      balOut = balIn - (qm[8] ? NONE : TWO) + onesS - zerosS;
    end
  end
endmodule

// File: rtl/tmds_ctrl.sv
module tmds_ctrl
  import tmds_reg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrite,
  input  logic busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] singleWord,
  input  logic [LANES-1:0][WORD_W-1:0] doubleWord,
  output logic [WORD_W-1:0] busRdata,
  output cfg_t cfg,
  output strobe_t strb
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_COL = ADDR_W'(ADR_COLOUR);
  localparam logic [ADDR_W-1:0] A_PK1 = ADDR_W'(ADR_PEEK1);
  localparam logic [ADDR_W-1:0] A_POP1 = ADDR_W'(ADR_POP1);
  localparam logic [ADDR_W-1:0] A_DBL = ADDR_W'(ADR_DBL_BASE);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(ADR_DBL_BASE + 2 * LANES);

  logic readOnly;
  logic ctrlWrite;
  logic [ADDR_W-1:0] dblOff;
  logic [WORD_W-1:0] ctrlView;

  assign readOnly = busRead && !busWrite;
  assign ctrlWrite = busWrite && busAddr == A_CTRL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (ctrlWrite) begin
      cfg.rot <= busWdata[LANES*ROT_W-1:0];
      cfg.nbits <= busWdata[12 +: LANES*NB_W];
      cfg.interleave <= busWdata[23];
      cfg.pixShift <= busWdata[26:24];
      cfg.noShift <= busWdata[27];
    end
  end

  assign strb.clearBal = ctrlWrite && busWdata[CLR_BIT];
  assign strb.wrColour = busWrite && busAddr == A_COL;
  assign strb.popSingle = readOnly && busAddr == A_POP1;

  for (genvar k = 0; k < LANES; k++) begin : g_pop
    assign strb.popDouble[k] = readOnly && busAddr == A_DBL + ADDR_W'(2 * k + 1);
  end

  assign ctrlView = {4'b0, cfg.noShift, cfg.pixShift, cfg.interleave, 2'b0,
                     cfg.nbits, cfg.rot};
  assign dblOff = (busAddr - A_DBL) >> 1;

  always_comb begin
    busRdata = '0;
    if (readOnly) begin
      if (busAddr == A_CTRL) begin
        busRdata = ctrlView;
      end else if (busAddr == A_PK1 || busAddr == A_POP1) begin
        busRdata = singleWord;
      end else if (busAddr >= A_DBL && busAddr < A_END) begin
        busRdata = doubleWord[dblOff[1:0]];
      end
    end
  end
endmodule

// File: rtl/tmds_datapath.sv
module tmds_datapath
  import tmds_reg_pkg::*;
#(
  parameter int BAL_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfg,
  input  strobe_t strb,
  input  logic [WORD_W-1:0] colourIn,
  output logic [WORD_W-1:0] singleWord,
  output logic [LANES-1:0][WORD_W-1:0] doubleWord
);
  localparam int GAP = 16 - SYM_W;

  logic [WORD_W-1:0] colourQ;
  logic [7:0] shiftAmt;
  logic [WORD_W-1:0] colShift1;
  logic [WORD_W-1:0] colShift2;
  logic [WORD_W-1:0] colB;

  assign shiftAmt = (cfg.pixShift == '0) ? 8'd0 : (8'd1 << cfg.pixShift);
  assign colShift1 = colourQ >> shiftAmt;
  assign colShift2 = colShift1 >> shiftAmt;
  assign colB = cfg.noShift ? colourQ : colShift1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colourQ <= '0;
    end else if (strb.wrColour) begin
      colourQ <= colourIn;
    end else if (strb.popSingle) begin
      colourQ <= colShift1;
    end else if (|strb.popDouble) begin
      colourQ <= cfg.noShift ? colShift1 : colShift2;
    end
  end

  assign singleWord[WORD_W-1:LANES*SYM_W] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] byteA;
    logic [7:0] byteB;
    logic [SYM_W-1:0] symA;
    logic [SYM_W-1:0] symB;
    logic signed [BAL_W-1:0] balQ;
    logic signed [BAL_W-1:0] balA;
    logic signed [BAL_W-1:0] balB;

    assign byteA = laneBits(colourQ, cfg.rot[k], cfg.nbits[k]);
    assign byteB = laneBits(colB, cfg.rot[k], cfg.nbits[k]);

    tmds_lane_enc #(.BAL_W(BAL_W)) u_encA (
      .dataIn(byteA), .balIn(balQ), .sym(symA), .balOut(balA)
    );
    tmds_lane_enc #(.BAL_W(BAL_W)) u_encB (
      .dataIn(byteB), .balIn(balA), .sym(symB), .balOut(balB)
    );

    always_ff @(posedge clk) begin
      if (!rstN || strb.clearBal) begin
        balQ <= '0;
      end else if (strb.popSingle) begin
        balQ <= balA;
      end else if (strb.popDouble[k]) begin
        balQ <= balB;
      end
    end

    assign singleWord[k*SYM_W +: SYM_W] = symA;
    assign doubleWord[k] = {{GAP{1'b0}}, symB, {GAP{1'b0}}, symA};
  end
endmodule

// File: rtl/tmds_reg_encoder.sv
module tmds_reg_encoder
  import tmds_reg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BAL_W = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrite,
  input  logic busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);
  cfg_t cfg;
  strobe_t strb;
  logic [WORD_W-1:0] singleWord;
  logic [LANES-1:0][WORD_W-1:0] doubleWord;

  tmds_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .singleWord(singleWord),
    .doubleWord(doubleWord), .busRdata(busRdata), .cfg(cfg), .strb(strb)
  );

  tmds_datapath #(.BAL_W(BAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .colourIn(busWdata),
    .singleWord(singleWord), .doubleWord(doubleWord)
  );
endmodule

// File: rtl/tmds_reg_encoder_chk.sv
module tmds_reg_encoder_chk #(
  parameter int ADDR_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic busWrite,
  input logic busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata
);
  logic rdOnly;
  assign rdOnly = busRead && !busWrite;

  // R5
  a_r5_single_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && (busAddr == 2 || busAddr == 3)) |-> busRdata[31:30] == 2'b0);

  // R6
  a_r6_double_gaps_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && busAddr >= 4 && busAddr <= 9) |->
      (busRdata[31:26] == 6'b0 && busRdata[15:10] == 6'b0));

  // R2
  a_r2_ctrl_spare_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && busAddr == 0) |-> (busRdata[31:28] == 4'b0 && busRdata[22:21] == 2'b0));

  // R7
  a_r7_peek_repeat_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rdOnly && busAddr == 2 && $past(rstN) && $past(rdOnly && busAddr == 2))
      |-> busRdata == $past(busRdata));

  // R10
  a_r10_clear_gives_zero_bal: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN && busWrite && busAddr == 0 && busWdata[28]) && rdOnly && busAddr == 2)
      |-> (busRdata[9] != busRdata[8] && busRdata[19] != busRdata[18]
           && busRdata[29] != busRdata[28]));

  // R11
  a_r11_idle_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!busRead || (rdOnly && (busAddr == 1 || busAddr > 9))) |-> busRdata == 32'b0);
endmodule

bind tmds_reg_encoder tmds_reg_encoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tmds_reg_encoder_tb.sv
module tmds_reg_encoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0;
  logic busRead = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] mCtrl;
  logic [31:0] mColour;
  int mBal [3];

  always #5 clk = ~clk;

  tmds_reg_encoder u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic int popCount8(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic void encOne(input int d, input int balIn, output int sym, output int balOut);
    int ones = popCount8(d);
    int useX = (ones > 4 || (ones == 4 && (d & 1) == 0)) ? 1 : 0;
    int qm = d & 1;
    int prev = d & 1;
    int q8 = 1 - useX;
    int n1, n0;
    for (int i = 1; i < 8; i++) begin
      int b = ((d >> i) & 1) ^ prev ^ useX;
      qm |= b << i;
      prev = b;
    end
    n1 = popCount8(qm);
    n0 = 8 - n1;
    if (balIn == 0 || n1 == n0) begin
      sym = ((1 - q8) << 9) | (q8 << 8) | (q8 == 1 ? qm : (~qm & 255));
      balOut = balIn + (q8 == 1 ? n1 - n0 : n0 - n1);
    end else if ((balIn > 0 && n1 > n0) || (balIn < 0 && n0 > n1)) begin
      sym = (1 << 9) | (q8 << 8) | (~qm & 255);
      balOut = balIn + 2 * q8 + n0 - n1;
    end else begin
      sym = (q8 << 8) | qm;
      balOut = balIn - 2 * (1 - q8) + n1 - n0;
    end
  endfunction

  function automatic logic [31:0] shiftOnce(input logic [31:0] c);
    int s = int'((mCtrl >> 24) & 7);
    int amt;
    if (s == 0) return c;
    amt = 1 << s;
    if (amt >= 32) return 32'h0;
    return c >> amt;
  endfunction

  function automatic int extractByte(input logic [31:0] c, input int k);
    int r = int'((mCtrl >> (4 * k)) & 15);
    int n = int'((mCtrl >> (12 + 3 * k)) & 7);
    int low = int'(c & 32'hFFFF);
    int turned = ((low >> r) | (low << (16 - r))) & 16'hFFFF;
    int mask = (8'hFF << (7 - n)) & 8'hFF;
    return turned & mask & 8'hFF;
  endfunction

  function automatic logic [31:0] colourB();
    return ((mCtrl >> 27) & 1) ? mColour : shiftOnce(mColour);
  endfunction

  // expected read data; updates model when commit is set
  function automatic logic [31:0] modelRead(input int addr, input bit commit);
    logic [31:0] w = '0;
    int sym, nb, symB, nbB;
    if (addr == 0) begin
      w = mCtrl;
    end else if (addr == 2 || addr == 3) begin
      int newBal [3];
      for (int k = 0; k < 3; k++) begin
        encOne(extractByte(mColour, k), mBal[k], sym, nb);
        newBal[k] = nb;
        w |= 32'(sym) << (10 * k);
      end
      if (commit && addr == 3) begin
        for (int k = 0; k < 3; k++) mBal[k] = newBal[k];
        mColour = shiftOnce(mColour);
      end
    end else if (addr >= 4 && addr <= 9) begin
      int k = (addr - 4) / 2;
      encOne(extractByte(mColour, k), mBal[k], sym, nb);
      encOne(extractByte(colourB(), k), nb, symB, nbB);
      w = 32'(sym) | (32'(symB) << 16);
      if (commit && (addr % 2) == 1) begin
        mBal[k] = nbB;
        mColour = ((mCtrl >> 27) & 1) ? shiftOnce(mColour) : shiftOnce(shiftOnce(mColour));
      end
    end
    return w;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one bus operation per cycle; drive at negedge, compare before posedge
  task automatic doOp(input bit wr, input bit rd, input int addr, input logic [31:0] data,
                      input string tag);
    logic [31:0] exp;
    @(negedge clk);
    busWrite = wr;
    busRead = rd;
    busAddr = addr[3:0];
    busWdata = data;
    #1;
    exp = (rd && !wr) ? modelRead(addr, 1'b1) : 32'h0;
    check(busRdata, exp, tag);
    if (wr && addr == 0) begin
      mCtrl = data & 32'h0F9F_FFFF;
      if (data[28]) for (int k = 0; k < 3; k++) mBal[k] = 0;
    end else if (wr && addr == 1) begin
      mColour = data;
    end
  endtask

  task automatic idle(input string tag);
    doOp(1'b0, 1'b0, 0, 32'h0, tag);
  endtask

  initial begin
    mCtrl = '0;
    mColour = '0;
    for (int k = 0; k < 3; k++) mBal[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of control, colour and balance
    doOp(0, 1, 0, 0, "R1 ctrl after reset");
    doOp(0, 1, 2, 0, "R1 peek of zero colour");
    check(busRdata, {2'b0, 10'h100, 10'h100, 10'h100}, "R1 zero encodings");
    // R11: idle and write-only / spare addresses read zero
    idle("R11 idle");
    doOp(0, 1, 1, 0, "R11 colour address reads zero");
    doOp(0, 1, 12, 0, "R11 spare address");
    // R2: control readback, strobe not stored
    doOp(1, 0, 0, 32'hFFFF_FFFF, "R2 ctrl write");
    doOp(0, 1, 0, 0, "R2 ctrl readback");
    doOp(1, 0, 0, 32'h0000_0000, "R2 ctrl zero");
    // R3/R4/R5: extraction and single encoding
    doOp(1, 0, 1, 32'h1234_A5F0, "R3 colour write");
    doOp(0, 1, 2, 0, "R5 peek single");
    doOp(1, 0, 0, 32'h0017_E840, "R3 rot and widths");
    doOp(0, 1, 2, 0, "R3 peek rotated");
    // R7: repeated previews
    doOp(0, 1, 2, 0, "R7 repeat peek");
    doOp(0, 1, 4, 0, "R7 double peek");
    doOp(0, 1, 4, 0, "R7 double peek again");
    // R8: consume single with shift code 3
    doOp(1, 0, 0, 32'h033F_F000, "R8 shift 8");
    doOp(0, 1, 3, 0, "R8 pop single");
    doOp(0, 1, 2, 0, "R8 after pop");
    doOp(0, 1, 3, 0, "R4 pop with balance");
    doOp(0, 1, 2, 0, "R4 nonzero balance");
    // R6/R9: doubles, with and without no-shift
    doOp(1, 0, 1, 32'hDEAD_BEEF, "R6 colour");
    doOp(0, 1, 6, 0, "R6 peek double lane1");
    doOp(0, 1, 7, 0, "R9 pop double lane1");
    doOp(0, 1, 2, 0, "R9 lanes after double pop");
    doOp(1, 0, 0, 32'h0A3F_F000, "R9 noshift");
    doOp(0, 1, 9, 0, "R9 pop double noshift");
    doOp(0, 1, 2, 0, "R9 after noshift pop");
    // R10: clear balance
    doOp(1, 0, 0, 32'h103F_F000, "R10 clear");
    doOp(0, 1, 2, 0, "R10 after clear");
    // R8: shift of 32 or more clears
    doOp(1, 0, 0, 32'h063F_F000, "R8 shift 64");
    doOp(0, 1, 3, 0, "R8 pop");
    doOp(0, 1, 2, 0, "R8 colour cleared");

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 19);
      if (r < 2) begin
        logic [31:0] v = $urandom;
        v[28] = ($urandom_range(0, 3) == 0);
        doOp(1, 0, 0, v, "R2 R10 random ctrl");
      end else if (r < 5) begin
        doOp(1, 0, 1, $urandom, "R3 random colour");
      end else if (r < 7) begin
        doOp(0, 1, 2, 0, "R4 R7 random peek");
      end else if (r < 10) begin
        doOp(0, 1, 3, 0, "R8 random pop");
      end else if (r < 16) begin
        doOp(0, 1, $urandom_range(4, 9), 0, "R6 R9 random double");
      end else if (r == 16) begin
        doOp(0, 1, 0, 0, "R2 random ctrl read");
      end else if (r == 17) begin
        doOp(0, 1, $urandom_range(10, 15), 0, "R11 spare read");
      end else begin
        idle("R11 random idle");
      end
    end
    idle("R11 final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule